// File: doc/BRIEF.md
# Pulse and Duty-Cycle Capture Unit

This block measures an external digital signal in cycles of its own clock. The input is first passed through a synchronizer. Edges are then found on the synchronized copy. A polarity control chooses whether a rising or a falling edge begins a measurement.

The unit has two measuring modes:
- **Pulse mode** times one phase of the input, from the starting edge to the opposite edge.
- **Duty mode** times that phase and also the whole period. The period runs from one starting edge to the next. The two results are stored in separate registers.

A repeat control chooses between two behaviours. The unit either keeps measuring and refreshes its results every time, or it takes one measurement and then halts until it is disabled.

Every completed measurement raises an interrupt flag. The flag comes with an enable-gated interrupt output and an overflow flag. The overflow flag marks a completion that arrived while the previous one was still uncleared. The width counter saturates, so a phase that is too long reads as all ones and still completes.

Top module: `pulse_capture_unit`

## Requirements
- R1: After reset `pulseWidth`, `cycleWidth`, `irqRaw`, `irqOverflow`, `irq` and `busy` are all 0.
- R2: In pulse mode (`dutyMode`=0) with `fallStart`=0, an input held high for N clock cycles gives `pulseWidth` = N.
- R3: With `fallStart`=1 a falling edge starts the measurement, so the measured phase is the low phase of the input.
- R4: In duty mode (`dutyMode`=1) `pulseWidth` holds the length of the phase after the starting edge. `cycleWidth` holds the number of cycles between two consecutive starting edges. `cycleWidth` changes only when a measurement completes.
- R5: With `loopMode`=0 only the first measurement after `enable` rises is taken. Later edges change neither result, set no overflow, and leave `busy` at 0.
- R6: With `loopMode`=1 every measurement replaces the results, so the results always reflect the latest completed period.
- R7: Each completion sets `irqRaw`. `irq` equals `irqRaw` while `irqEn`=1 and is 0 while `irqEn`=0. A one-cycle `irqClear` pulse clears `irqRaw` and `irqOverflow`.
- R8: A completion while `irqRaw` is already set (and no clear is given in that cycle) sets `irqOverflow`.
- R9: A phase longer than 2^W-1 cycles yields a result of all ones, and the measurement still completes.
- R10: While `enable`=0 no measurement runs: `busy` stays 0, `irqRaw` stays clear and the results keep their values.
- R11: A pulse-mode measurement leaves `cycleWidth` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock, also the unit of measurement |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run control; low returns the unit to idle |
| dutyMode | input | 1 | 0 selects pulse mode, 1 selects duty mode |
| fallStart | input | 1 | 0: rising edge starts, 1: falling edge starts |
| loopMode | input | 1 | 1 repeats measurements, 0 takes one and halts |
| irqEn | input | 1 | Gates `irqRaw` onto `irq` |
| irqClear | input | 1 | One-cycle pulse clearing both interrupt flags |
| capIn | input | 1 | Asynchronous signal to be measured |
| pulseWidth | output | W | Width of the measured phase |
| cycleWidth | output | W | Full period width (duty mode) |
| busy | output | 1 | A measurement is in progress |
| irqRaw | output | 1 | Completion flag before gating |
| irqOverflow | output | 1 | Completion seen while the flag was still set |
| irq | output | 1 | Gated interrupt output |

## Verification
A table of waveforms is applied in both modes and with both edge polarities. Its entries have unequal high and low phases, so a swapped phase or a wrong starting edge gives a different number. Entries include a one-cycle phase and very short periods, which catch off-by-one errors through the synchronizer path. Directed runs cover the following:
- two different pulses in single mode, to tell single from loop behaviour;
- a loop run whose second period differs from the first;
- a phase long enough to saturate the counter;
- pulses sent while the unit is disabled;
- interrupt gating and clearing.

// File: rtl/capPkg.sv
package capPkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_ACTIVE,
    ST_REST,
    ST_HALT
  } capState_e;

  typedef struct packed {
    logic cntClear;
    logic cntLoad;
    logic cntRun;
    logic latchPulse;
    logic latchCycle;
  } capStrobe_t;
endpackage

// File: rtl/capSync.sv
module capSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  input  logic fallStart,
  output logic startEdge,
  output logic endEdge
);
  localparam int LAST = STAGES;

  logic [LAST:0] pipe;
  logic synced;
  logic prev;
  logic rise;
  logic fall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[LAST-1:0], rawIn};
  end

  assign synced = pipe[LAST-1];
  assign prev   = pipe[LAST];
  assign rise   = synced & ~prev;
  assign fall   = ~synced & prev;

  assign startEdge = fallStart ? fall : rise;
  assign endEdge   = fallStart ? rise : fall;
endmodule

// File: rtl/capCtrl.sv
module capCtrl
  import capPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       dutyMode,
  input  logic       loopMode,
  input  logic       startEdge,
  input  logic       endEdge,
  input  logic       irqClear,
  output capStrobe_t strobe,
  output logic       done,
  output logic       busy,
  output logic       irqRaw,
  output logic       irqOverflow
);
  capState_e state;
  capState_e nxt;

  always_comb begin
    nxt    = state;
    strobe = '0;
    done   = 1'b0;
    if (!enable) begin
      nxt             = ST_IDLE;
      strobe.cntClear = 1'b1;
    end else begin
      case (state)
        ST_IDLE: nxt = ST_ARM;
        ST_ARM: begin
          if (startEdge) begin
            strobe.cntLoad = 1'b1;
            nxt            = ST_ACTIVE;
          end
        end
        ST_ACTIVE: begin
          strobe.cntRun = 1'b1;
          if (endEdge) begin
            strobe.latchPulse = 1'b1;
            if (dutyMode) begin
              nxt = ST_REST;
            end else begin
              done = 1'b1;
              nxt  = loopMode ? ST_ARM : ST_HALT;
            end
          end
        end
        ST_REST: begin
          strobe.cntRun = 1'b1;
          if (startEdge) begin
            strobe.latchCycle = 1'b1;
            done              = 1'b1;
            if (loopMode) begin
              strobe.cntLoad = 1'b1;
              nxt            = ST_ACTIVE;
            end else begin
              nxt = ST_HALT;
            end
          end
        end
        default: nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      irqRaw      <= 1'b0;
      irqOverflow <= 1'b0;
    end else begin
      state       <= nxt;
      irqRaw      <= done | (irqRaw & ~irqClear);
      irqOverflow <= (done & irqRaw & ~irqClear) | (irqOverflow & ~irqClear);
    end
  end

  assign busy = (state == ST_ACTIVE) || (state == ST_REST);
endmodule

// File: rtl/capDatapath.sv
module capDatapath
  import capPkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  capStrobe_t   strobe,
  output logic [W-1:0] pulseWidth,
  output logic [W-1:0] cycleWidth
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
  localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.cntClear) begin
      count <= '0;
    end else if (strobe.cntLoad) begin
      count <= CNT_ONE;
    end else if (strobe.cntRun && (count != CNT_MAX)) begin
      count <= count + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseWidth <= '0;
      cycleWidth <= '0;
    end else begin
      if (strobe.latchPulse) pulseWidth <= count;
      if (strobe.latchCycle) cycleWidth <= count;
    end
  end
endmodule

// File: rtl/pulse_capture_unit.sv
module pulse_capture_unit
  import capPkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         dutyMode,
  input  logic         fallStart,
  input  logic         loopMode,
  input  logic         irqEn,
  input  logic         irqClear,
  input  logic         capIn,
  output logic [W-1:0] pulseWidth,
  output logic [W-1:0] cycleWidth,
  output logic         busy,
  output logic         irqRaw,
  output logic         irqOverflow,
  output logic         irq
);
  capStrobe_t strobe;
  logic startEdge;
  logic endEdge;
  logic done;

  capSync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .rawIn(capIn), .fallStart(fallStart),
    .startEdge(startEdge), .endEdge(endEdge)
  );

  capCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .dutyMode(dutyMode),
    .loopMode(loopMode), .startEdge(startEdge), .endEdge(endEdge),
    .irqClear(irqClear), .strobe(strobe), .done(done), .busy(busy),
    .irqRaw(irqRaw), .irqOverflow(irqOverflow)
  );

  capDatapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .pulseWidth(pulseWidth), .cycleWidth(cycleWidth)
  );

  assign irq = irqRaw & irqEn;
endmodule

// File: rtl/pulse_capture_unit_chk.sv
module pulse_capture_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         enable,
  input logic         loopMode,
  input logic         irqClear,
  input logic         done,
  input logic         busy,
  input logic         irqRaw,
  input logic         irqOverflow,
  input logic [W-1:0] cycleWidth
);
  // R7: the raw flag only rises because a measurement completed
  assert_raw_from_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqRaw) |-> $past(done));

  // R8: a second completion on an uncleared flag marks overflow
  assert_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    (done && irqRaw && !irqClear) |=> irqOverflow);

  // R5: single mode halts after its one measurement
  assert_single_halts_R5: assert property (@(posedge clk) disable iff (!rstN)
    (done && !loopMode) |=> !busy);

  // R10: disabling drops any measurement in progress
  assert_idle_when_off_R10: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !busy);

  // R4: the period result moves only at a completion
  assert_cycle_on_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    !done |=> $stable(cycleWidth));
endmodule

bind pulse_capture_unit pulse_capture_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .loopMode(loopMode),
  .irqClear(irqClear), .done(done), .busy(busy), .irqRaw(irqRaw),
  .irqOverflow(irqOverflow), .cycleWidth(cycleWidth)
);

// File: tb/pulse_capture_unit_tb.sv
module pulse_capture_unit_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, dutyMode = 1'b0, fallStart = 1'b0, loopMode = 1'b0;
  logic irqEn = 1'b0, irqClear = 1'b0, capIn = 1'b0;
  logic [W-1:0] pulseWidth, cycleWidth;
  logic busy, irqRaw, irqOverflow, irq;

  int checks = 0;
  int fails = 0;
  int expCycle = 0;

  always #5 clk = ~clk;

  pulse_capture_unit #(.W(W)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .dutyMode(dutyMode),
    .fallStart(fallStart), .loopMode(loopMode), .irqEn(irqEn),
    .irqClear(irqClear), .capIn(capIn), .pulseWidth(pulseWidth),
    .cycleWidth(cycleWidth), .busy(busy), .irqRaw(irqRaw),
    .irqOverflow(irqOverflow), .irq(irq)
  );

  // columns: duty, fallStart, highLen, lowLen, expPulse, expCycle (-1 = unchanged)
  localparam int VEC [0:5][0:5] = '{
    '{0, 0, 5, 7, 5, -1},
    '{0, 1, 4, 9, 9, -1},
    '{1, 0, 6, 10, 6, 16},
    '{1, 1, 3, 8, 8, 11},
    '{0, 0, 1, 3, 1, -1},
    '{1, 0, 2, 2, 2, 4}
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drv(logic v, int n);
    capIn = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic restart(logic duty, logic fall, logic loopSel);
    enable = 1'b0;
    irqClear = 1'b1;
    @(negedge clk);
    irqClear = 1'b0;
    dutyMode = duty;
    fallStart = fall;
    loopMode = loopSel;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pulseWidth", int'(pulseWidth), 0);
    check("R1 cycleWidth", int'(cycleWidth), 0);
    check("R1 irqRaw", int'(irqRaw), 0);
    check("R1 irqOverflow", int'(irqOverflow), 0);
    check("R1 busy", int'(busy), 0);

    // table walk, single mode: R2 R3 R4 R11
    for (int i = 0; i < 6; i++) begin
      restart(VEC[i][0][0], VEC[i][1][0], 1'b0);
      drv(1'b0, 4);
      for (int p = 0; p < 2; p++) begin
        drv(1'b1, VEC[i][2]);
        drv(1'b0, VEC[i][3]);
      end
      drv(1'b0, 6);
      if (VEC[i][5] >= 0) expCycle = VEC[i][5];
      check(VEC[i][0] != 0 ? "R4 pulse" : (VEC[i][1] != 0 ? "R3 pulse" : "R2 pulse"),
            int'(pulseWidth), VEC[i][4]);
      check(VEC[i][0] != 0 ? "R4 cycle" : "R11 cycle", int'(cycleWidth), expCycle);
      check("R7 raw set", int'(irqRaw), 1);
      check("R5 no overflow", int'(irqOverflow), 0);
    end

    // R5: second, different pulse ignored in single mode
    restart(1'b0, 1'b0, 1'b0);
    drv(1'b0, 4); drv(1'b1, 5); drv(1'b0, 6); drv(1'b1, 9); drv(1'b0, 6);
    check("R5 first pulse kept", int'(pulseWidth), 5);
    check("R5 overflow clear", int'(irqOverflow), 0);
    check("R5 halted", int'(busy), 0);

    // R7 gating and clear
    irqEn = 1'b0;
    @(negedge clk);
    check("R7 irq gated off", int'(irq), 0);
    irqEn = 1'b1;
    @(negedge clk);
    check("R7 irq gated on", int'(irq), 1);
    irqClear = 1'b1;
    @(negedge clk);
    irqClear = 1'b0;
    check("R7 cleared", int'(irqRaw), 0);

    // R6 R8: loop mode, second period differs
    restart(1'b1, 1'b0, 1'b1);
    drv(1'b0, 4); drv(1'b1, 3); drv(1'b0, 5); drv(1'b1, 7); drv(1'b0, 2);
    drv(1'b1, 8);
    check("R6 loop pulse", int'(pulseWidth), 7);
    check("R6 loop cycle", int'(cycleWidth), 9);
    check("R8 overflow", int'(irqOverflow), 1);
    check("R7 irq out", int'(irq), 1);
    irqClear = 1'b1;
    @(negedge clk);
    irqClear = 1'b0;
    check("R7 overflow cleared", int'(irqOverflow), 0);
    drv(1'b0, 6);

    // R9 saturation
    restart(1'b0, 1'b0, 1'b0);
    drv(1'b0, 4); drv(1'b1, 300); drv(1'b0, 6);
    check("R9 clamp", int'(pulseWidth), (1 << W) - 1);
    check("R9 completes", int'(irqRaw), 1);

    // R10 disabled: nothing happens
    enable = 1'b0;
    irqClear = 1'b1;
    @(negedge clk);
    irqClear = 1'b0;
    drv(1'b0, 3); drv(1'b1, 4); drv(1'b0, 6);
    check("R10 no flag", int'(irqRaw), 0);
    check("R10 idle", int'(busy), 0);
    check("R10 result kept", int'(pulseWidth), (1 << W) - 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule